// File: doc/BRIEF.md
# Eight-Channel Reloading Down-Counter Timer Bank

This block holds eight independent 32-bit down-counters behind a word-addressed register port. Each counter counts down either on every system clock or only on cycles where an external 1 MHz tick strobe is high. When a running count has reached zero, its next step loads the channel's reload value. That step can latch a sticky interrupt, and a one-cycle match pulse marks each step that lands on either of two compare values. Software measures elapsed time as the reload value minus the live count.

All eight channels share one packed control word with four bits per channel. A second address clears control bits with write-one-to-clear semantics, so one channel can be stopped without a read-modify-write of its neighbours' bits. Any write that turns a channel's enable off also reloads that channel's count on the same clock edge. Each channel owns a four-word slot. Three slots sit below the control words and the remaining five sit above them.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every control bit, count, reload and match register reads zero, and all `irq` and `match_pulse` bits are low.
- R2: `bus_addr` is a word index (byte offset divided by four). Channels 1 to 3 use words 0 to 11 and channels 4 to 8 use words 16 to 35, four words per channel in the order live count, reload, match A, match B. The packed control word is word 12 and its clear alias is word 15. Reload and the two match registers read back what was written.
- R3: In the control word, channel n (counted from 1) owns bits 4(n-1) to 4(n-1)+3. Bit +0 is enable, bit +1 selects the 1 MHz tick as the count source, bit +2 enables the interrupt, and bit +3 is reserved, cannot be set and always reads 0.
- R4: An enabled channel with bit +1 clear steps on every clock. A step from a nonzero count subtracts one, and a step from zero loads the reload value.
- R5: With bit +1 set, an enabled channel steps only on clocks where `tick_1m` is high and holds its count otherwise.
- R6: A write that changes a channel's enable from 1 to 0, through either control address, loads that channel's reload value into its count at the edge of that write.
- R7: A write to the reload register does not alter the running count. The new value is used only at the next wrap or disable.
- R8: A step from zero while bit +2 is set raises that channel's `irq`, which stays high while bit +2 stays set. It drops on the clock edge after bit +2 reads 0. Without bit +2, `irq` stays low.
- R9: Writing to the clear alias clears the control bits written as 1 and leaves the bits written as 0 unchanged. The alias always reads 0.
- R10: `match_pulse[n]` is high for exactly the one cycle after a step whose new count equals match A or match B. It is never high on a cycle that did not follow a step.
- R11: Writes to the live-count word, to words 13, 14 and 36 to 63 are ignored. Words 13, 14 and 36 to 63 read as 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | One-cycle strobe at 1 MHz, used by channels that select it |
| bus_addr | input | 6 | Word index for reads and writes |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 8 | Sticky interrupt per channel |
| match_pulse | output | 8 | One-cycle compare hit per channel |

## Verification
The hardest condition to create from the ports is a disable that lands while a channel is part-way through a count, after its reload register has already been rewritten. Only this condition separates "reload on disable" from "reload on wrap" and from "reload on write". The bench runs each channel for more than two full periods and rewrites the reload value mid-count. It checks that the count keeps its old trajectory, then clears the enable through the alias and expects the new reload value on the very next read. A second pass reaches the same condition for all channels at once: every channel is enabled in tick mode with no tick applied, so every count is frozen, and a single zero write to the control word then disables all eight together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Field layout inside one channel's nibble of the control word
  localparam int FLD_W  = 4;
  localparam int EN_B   = 0;
  localparam int SRC_B  = 1;
  localparam int IE_B   = 2;
  localparam int RSV_B  = 3;

  // Word order inside one channel slot
  localparam logic [1:0] RG_COUNT  = 2'd0;
  localparam logic [1:0] RG_RELOAD = 2'd1;
  localparam logic [1:0] RG_MATCHA = 2'd2;
  localparam logic [1:0] RG_MATCHB = 2'd3;

  // Word index of a channel slot, given how many slots precede the control words
  function automatic int slot_base(input int idx, input int lo_slots);
    return (idx < lo_slots) ? FLD_W * idx : FLD_W * (idx + 1);
  endfunction
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
  parameter int N_TMR    = 8,
  parameter int LO_SLOTS = 3,
  parameter int AW       = 6
) (
  input  logic [AW-1:0]    addr,
  output logic [N_TMR-1:0] slot_sel,
  output logic [1:0]       reg_sel,
  output logic             ctl_sel,
  output logic             clr_sel
);
  import tmr_pkg::*;

  localparam int CTL_WORD = FLD_W * LO_SLOTS;
  localparam int CLR_WORD = CTL_WORD + 3;

  for (genvar i = 0; i < N_TMR; i++) begin : g_slot
    localparam logic [AW-3:0] SLOT_ID = (AW-2)'(slot_base(i, LO_SLOTS) / FLD_W);
    assign slot_sel[i] = (addr[AW-1:2] == SLOT_ID);
  end

  assign reg_sel = addr[1:0];
  assign ctl_sel = (addr == AW'(CTL_WORD));
  assign clr_sel = (addr == AW'(CLR_WORD));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          src_1m,
  input  logic          irq_en,
  input  logic          tick_1m,
  input  logic          dis_evt,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] match_a,
  input  logic [CW-1:0] match_b,
  output logic [CW-1:0] cnt,
  output logic          pend,
  output logic          mpulse,
  output logic          step,
  output logic          uflow
);
  logic [CW-1:0] cnt_nxt;

  // One count step: wrap to the reload value from zero, else decrement
  function automatic logic [CW-1:0] step_val(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] rel);
    return (cur == '0) ? rel : cur - CW'(1);
  endfunction

  assign step  = en & (src_1m ? tick_1m : 1'b1);
  assign uflow = step & (cnt == '0);

  always_comb begin
    if (dis_evt)   cnt_nxt = reload;
    else if (step) cnt_nxt = step_val(cnt, reload);
    else           cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend   <= 1'b0;
      mpulse <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      pend   <= irq_en & (pend | uflow);
      mpulse <= step & ~dis_evt & ((cnt_nxt == match_a) | (cnt_nxt == match_b));
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int N_TMR    = 8,
  parameter int CW       = 32,
  parameter int LO_SLOTS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1m,
  input  logic [5:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  output logic [N_TMR-1:0] irq,
  output logic [N_TMR-1:0] match_pulse
);
  import tmr_pkg::*;

  localparam int CB     = FLD_W * N_TMR;
  localparam int NWORDS = FLD_W * (N_TMR + 1);
  localparam int AW     = 6;

  function automatic logic [CB-1:0] live_mask();
    logic [CB-1:0] m;
    m = '0;
    for (int i = 0; i < N_TMR; i++) m[i*FLD_W +: RSV_B] = '1;
    return m;
  endfunction
  localparam logic [CB-1:0] LIVE = live_mask();

  logic [N_TMR-1:0] slot_sel;
  logic [1:0]       reg_sel;
  logic             ctl_sel, clr_sel;
  logic [CB-1:0]    ctrl_q, ctl_nxt;
  logic [N_TMR-1:0] dis_evt_w, uflow_w, step_w;
  logic [CW-1:0]    cnt_w [N_TMR];
  logic [CW-1:0]    rel_q [N_TMR];
  logic [CW-1:0]    ma_q  [N_TMR];
  logic [CW-1:0]    mb_q  [N_TMR];
  logic [N_TMR*CW-1:0] cnt_flat, rel_flat;

  tmr_regdec #(.N_TMR(N_TMR), .LO_SLOTS(LO_SLOTS), .AW(AW)) u_dec (
    .addr(bus_addr), .slot_sel(slot_sel), .reg_sel(reg_sel),
    .ctl_sel(ctl_sel), .clr_sel(clr_sel)
  );

  always_comb begin
    ctl_nxt = ctrl_q;
    if (bus_wr && ctl_sel)      ctl_nxt = bus_wdata[CB-1:0] & LIVE;
    else if (bus_wr && clr_sel) ctl_nxt = ctrl_q & ~bus_wdata[CB-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctl_nxt;
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    assign dis_evt_w[i] = ctrl_q[i*FLD_W + EN_B] & ~ctl_nxt[i*FLD_W + EN_B];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rel_q[i] <= '0;
        ma_q[i]  <= '0;
        mb_q[i]  <= '0;
      end else if (bus_wr && slot_sel[i]) begin
        case (reg_sel)
          RG_RELOAD: rel_q[i] <= bus_wdata;
          RG_MATCHA: ma_q[i]  <= bus_wdata;
          RG_MATCHB: mb_q[i]  <= bus_wdata;
          default:   ;
        endcase
      end
    end

    tmr_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q[i*FLD_W + EN_B]), .src_1m(ctrl_q[i*FLD_W + SRC_B]),
      .irq_en(ctrl_q[i*FLD_W + IE_B]), .tick_1m(tick_1m),
      .dis_evt(dis_evt_w[i]), .reload(rel_q[i]),
      .match_a(ma_q[i]), .match_b(mb_q[i]),
      .cnt(cnt_w[i]), .pend(irq[i]), .mpulse(match_pulse[i]),
      .step(step_w[i]), .uflow(uflow_w[i])
    );

    assign cnt_flat[i*CW +: CW] = cnt_w[i];
    assign rel_flat[i*CW +: CW] = rel_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel) bus_rdata = CW'(ctrl_q);
    for (int i = 0; i < N_TMR; i++) begin
      if (slot_sel[i] && (int'(bus_addr) < NWORDS)) begin
        case (reg_sel)
          RG_COUNT:  bus_rdata = cnt_w[i];
          RG_RELOAD: bus_rdata = rel_q[i];
          RG_MATCHA: bus_rdata = ma_q[i];
          default:   bus_rdata = mb_q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR    = 8,
  parameter int CW       = 32,
  parameter int LO_SLOTS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4*N_TMR-1:0]  ctrl,
  input logic [N_TMR-1:0]    uflow,
  input logic [N_TMR-1:0]    step,
  input logic [N_TMR-1:0]    dis_evt,
  input logic [N_TMR*CW-1:0] cnt_flat,
  input logic [N_TMR*CW-1:0] rel_flat,
  input logic [N_TMR-1:0]    irq,
  input logic [N_TMR-1:0]    match_pulse,
  input logic [5:0]          bus_addr,
  input logic [CW-1:0]       bus_rdata
);
  localparam logic [5:0] CLR_WORD = 6'(4 * LO_SLOTS + 3);

  // R9
  clr_alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CLR_WORD) |-> (bus_rdata == '0));

  for (genvar i = 0; i < N_TMR; i++) begin : g_a
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(uflow[i]));
    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[4*i+2] |=> !irq[i]);
    // R6
    dis_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_evt[i] |=> (cnt_flat[i*CW +: CW] == $past(rel_flat[i*CW +: CW])));
    // R4
    wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow[i] && !dis_evt[i]) |=> (cnt_flat[i*CW +: CW] == $past(rel_flat[i*CW +: CW])));
    // R3
    rsv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[4*i+3]);
    // R10
    match_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse[i] |-> $past(step[i]));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step[i] && !dis_evt[i]) |=> $stable(cnt_flat[i*CW +: CW]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR), .CW(CW), .LO_SLOTS(LO_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .uflow(uflow_w), .step(step_w),
  .dis_evt(dis_evt_w), .cnt_flat(cnt_flat), .rel_flat(rel_flat),
  .irq(irq), .match_pulse(match_pulse), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1m = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq, match_pulse;
  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int rel_m [8];

  tmr_bank dut (.clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .match_pulse(match_pulse));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int base_of(input int t);
    return (t < 3) ? 4 * t : 16 + 4 * (t - 3);
  endfunction

  // count m edges after the enabling write, starting from zero
  function automatic int exp_cnt(input int r, input int m);
    return (m == 0) ? 0 : r - ((m - 1) % (r + 1));
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 6'(a); #1; d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 unmapped reads
    for (int a = 0; a < 64; a++) begin
      rd(a, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 match_pulse", match_pulse, 0);

    // per-channel sweep: R2, R4, R6, R7, R8, R9, R10
    for (int t = 0; t < 8; t++) begin
      int r, b, m;
      r = 6 + t; b = base_of(t);
      wr(b + 1, 32'(r));
      wr(b + 2, 32'd3);
      wr(b + 3, 32'(r));
      rd(b + 1, v); chk("R2 reload readback", v, r);
      rd(b + 2, v); chk("R2 match A readback", v, 3);
      rd(b + 3, v); chk("R2 match B readback", v, r);
      wr(12, 32'h5 << (4 * t));
      m = 0;
      for (int k = 0; k <= 2 * r + 3; k++) begin
        int c;
        c = exp_cnt(r, m);
        rd(b, v); chk("R4 count", v, c);
        chk("R10 match pulse", match_pulse[t], (m >= 1 && (c == 3 || c == r)) ? 1 : 0);
        chk("R8 irq after wrap", irq[t], (m >= 1) ? 1 : 0);
        @(negedge clk); m++;
      end
      wr(b + 1, 32'd100); m++;
      rd(b, v); chk("R7 reload write keeps count", v, exp_cnt(r, m));
      wr(15, 32'h1 << (4 * t));
      rd(b, v); chk("R6 disable loads reload", v, 100);
      rd(12, v); chk("R9 alias clears only ones", v, 32'h4 << (4 * t));
      chk("R8 irq sticky", irq[t], 1);
      repeat (3) @(negedge clk);
      rd(b, v); chk("R6 held while disabled", v, 100);
      wr(15, 32'h0);
      rd(12, v); chk("R9 zeros have no effect", v, 32'h4 << (4 * t));
      wr(15, 32'h4 << (4 * t));
      chk("R8 irq held at clearing edge", irq[t], 1);
      @(negedge clk);
      chk("R8 irq drops", irq[t], 0);
      rd(12, v); chk("R9 ctrl empty", v, 0);
      rel_m[t] = 100;
    end

    // R5 tick-driven channel 4 (index 3)
    wr(base_of(3) + 1, 32'd4); rel_m[3] = 4;
    wr(12, 32'h3 << 12);
    repeat (5) @(negedge clk);
    rd(base_of(3), v); chk("R5 holds without tick", v, 100);
    for (int k = 0; k < 100; k++) begin
      tick_1m = 1'b1; @(negedge clk); tick_1m = 1'b0;
      if (k == 2) begin rd(base_of(3), v); chk("R5 three ticks", v, 97); end
      if (k == 99) begin rd(base_of(3), v); chk("R5 reaches zero", v, 0); end
      @(negedge clk);
    end
    tick_1m = 1'b1; @(negedge clk); tick_1m = 1'b0;
    rd(base_of(3), v); chk("R4 wrap on tick", v, 4);
    chk("R8 no irq without enable bit", irq[3], 0);

    // R3 reserved bits, R6 disable of all channels at once
    wr(12, 32'hFFFF_FFFF);
    rd(12, v); chk("R3 reserved bits read 0", v, 32'h7777_7777);
    wr(12, 32'h0);
    for (int t = 0; t < 8; t++) begin
      rd(base_of(t), v); chk("R6 bulk disable", v, rel_m[t]);
    end
    chk("R8 irq none", irq, 0);

    // R11 ignored writes
    wr(13, 32'hFFFF_FFFF); wr(14, 32'hFFFF_FFFF);
    wr(40, 32'hFFFF_FFFF); wr(63, 32'hFFFF_FFFF);
    wr(0, 32'd5);
    rd(12, v); chk("R11 ctrl untouched", v, 0);
    rd(0, v);  chk("R11 count not writable", v, 100);
    rd(1, v);  chk("R11 reload untouched", v, 100);
    rd(13, v); chk("R11 word 13 reads 0", v, 0);
    rd(14, v); chk("R11 word 14 reads 0", v, 0);
    rd(40, v); chk("R11 word 40 reads 0", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule